// File: doc/BRIEF.md
# Floating-Point Compare and Min/Max Unit

This block takes two single-precision operands and, in the same cycle, works out how they relate and which one an extremum selection picks. A 3-bit operation code picks one of six functions. Two are compares that return only a relation status: a signaling form and a quiet form. Four are selections that return one operand as a 32-bit result: max, min, maxNum and minNum. The unit has no clock and no state, so a pipeline stage around it decides when its outputs are captured.

Alongside the relation status and the selected value, the unit reports two exception bits. The invalid bit depends on which NaNs each function treats as an error. The subnormal-operand bit reports denormal inputs. A flush input, `flush_sub`, makes subnormal operands behave as zeros of the same sign and suppresses the subnormal bit.

Operation codes: 0 signaling compare, 1 quiet compare, 2 max, 3 min, 4 maxNum, 5 minNum, 6 and 7 reserved.

Top module: `fpcmp_unit`

## Requirements
- R1: `rel_status` is {UN, EQ, LT, GT} from bit 3 down to bit 0, and exactly one of its bits is set for every input.
- R2: If either operand is a NaN (exponent all ones, mantissa nonzero), UN is set. Otherwise the operands are compared numerically, and +0 equals -0 in the relation.
- R3: For operation code 0 (signaling compare), `flag_invalid` is set exactly when either operand is any NaN.
- R4: For operation codes 1 to 7, `flag_invalid` is set exactly when either operand is a signaling NaN, meaning mantissa bit 22 is 0 and the mantissa is nonzero.
- R5: Operation codes 0, 1, 6 and 7 drive `sel_result` to zero. Reserved codes 6 and 7 otherwise behave like the quiet compare.
- R6: Max (code 2) and min (code 3) return the larger or smaller operand, and -0 counts as less than +0. If either operand is a NaN they return the default quiet NaN 0x7FC00000.
- R7: maxNum (code 4) and minNum (code 5) return the other operand when exactly one operand is a quiet NaN. They return 0x7FC00000 when both operands are NaNs or when either is a signaling NaN. When neither operand is a NaN they select the same way as max and min.
- R8: `flag_subnormal` is set exactly when `flush_sub` is low and either operand is subnormal (exponent zero, mantissa nonzero), for every operation code.
- R9: When `flush_sub` is high, a subnormal operand is replaced by a zero of the same sign. That zero is used for both the relation and the selection, and a selection that picks the operand returns it as that zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First single-precision operand |
| op_b | input | 32 | Second single-precision operand |
| op_sel | input | 3 | Operation code |
| flush_sub | input | 1 | Treat subnormal operands as signed zero |
| rel_status | output | 4 | Relation {UN, EQ, LT, GT} |
| sel_result | output | 32 | Selected value for min/max operations |
| flag_invalid | output | 1 | Invalid-operation exception |
| flag_subnormal | output | 1 | Subnormal-operand exception |

## Verification
Random operands are drawn from a class mix: normals, both zeros, subnormals, infinities, quiet NaNs and signaling NaNs. This mix exercises sign handling, the zero ordering and the NaN rules of every operation code, with and without flushing. Directed pairs cover specific cases. A ±0 pair separates the compare's equality from the selection's ordering. Quiet-NaN and signaling-NaN pairs separate the signaling compare from the quiet compare, and maxNum from max. A subnormal paired against a zero shows whether flushing changes both the relation and the returned value.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
    typedef enum logic [2:0] {
        OP_CMP_SIG   = 3'd0,
        OP_CMP_QUIET = 3'd1,
        OP_MAX       = 3'd2,
        OP_MIN       = 3'd3,
        OP_MAXNUM    = 3'd4,
        OP_MINNUM    = 3'd5,
        OP_RSV6      = 3'd6,
        OP_RSV7      = 3'd7
    } fpcmp_op_e;

    localparam int REL_GT = 0;
    localparam int REL_LT = 1;
    localparam int REL_EQ = 2;
    localparam int REL_UN = 3;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W = EXP_W + MAN_W + 1
) (
    input  logic [W-1:0] raw,
    input  logic         flush,
    output logic [W-1:0] eff,
    output logic         is_nan,
    output logic         is_snan,
    output logic         is_sub,
    output logic         is_zero
);
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;

    always_comb begin
        ex      = raw[W-2:MAN_W];
        mn      = raw[MAN_W-1:0];
        is_nan  = (&ex) && (|mn);
        is_snan = is_nan && !mn[MAN_W-1];
        is_sub  = (ex == '0) && (|mn);
        if (flush && is_sub) begin
            eff = {raw[W-1], {(W-1){1'b0}}};
        end else begin
            eff = raw;
        end
        is_zero = (eff[W-2:0] == '0);
    end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_zero,
    input  logic         b_zero,
    output logic         gt,
    output logic         lt,
    output logic         eq,
    output logic         a_below_b
);
    logic         sa, sb;
    logic [W-2:0] ma, mb;
    logic         mag_gt, mag_lt;

    always_comb begin
        sa     = a[W-1];
        sb     = b[W-1];
        ma     = a[W-2:0];
        mb     = b[W-2:0];
        mag_gt = ma > mb;
        mag_lt = ma < mb;
        gt = 1'b0;
        lt = 1'b0;
        eq = 1'b0;
        if (a_zero && b_zero) begin
            eq = 1'b1;
        end else if (sa != sb) begin
            gt = sb;
            lt = sa;
        end else if (!mag_gt && !mag_lt) begin
            eq = 1'b1;
        end else begin
            gt = sa ? mag_lt : mag_gt;
            lt = sa ? mag_gt : mag_lt;
        end
        // total order for selection: -0 below +0
        if (a == b) begin
            a_below_b = 1'b0;
        end else if (sa != sb) begin
            a_below_b = sa;
        end else begin
            a_below_b = sa ? mag_gt : mag_lt;
        end
    end
endmodule

// File: rtl/fpcmp_select.sv
module fpcmp_select
    import fpcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W = EXP_W + MAN_W + 1
) (
    input  fpcmp_op_e    op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_nan,
    input  logic         b_nan,
    input  logic         any_snan,
    input  logic         a_below_b,
    output logic [W-1:0] result
);
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic [W-1:0] hi, lo;

    always_comb begin
        hi = a_below_b ? b : a;
        lo = a_below_b ? a : b;
        unique case (op)
            OP_MAX, OP_MIN: begin
                if (a_nan || b_nan) result = QNAN;
                else                result = (op == OP_MAX) ? hi : lo;
            end
            OP_MAXNUM, OP_MINNUM: begin
                if (any_snan || (a_nan && b_nan)) result = QNAN;
                else if (a_nan)                   result = b;
                else if (b_nan)                   result = a;
                else                              result = (op == OP_MAXNUM) ? hi : lo;
            end
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
    import fpcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W = EXP_W + MAN_W + 1
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [2:0]   op_sel,
    input  logic         flush_sub,
    output logic [3:0]   rel_status,
    output logic [W-1:0] sel_result,
    output logic         flag_invalid,
    output logic         flag_subnormal
);
    logic [W-1:0] eff   [2];
    logic [1:0]   nan_v, snan_v, sub_v, zero_v;
    logic         gt, lt, eq, a_below_b;
    fpcmp_op_e    op;

    assign op = fpcmp_op_e'(op_sel);

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cls_i (
            .raw     (i == 0 ? op_a : op_b),
            .flush   (flush_sub),
            .eff     (eff[i]),
            .is_nan  (nan_v[i]),
            .is_snan (snan_v[i]),
            .is_sub  (sub_v[i]),
            .is_zero (zero_v[i])
        );
    end

    fpcmp_order #(.W(W)) ord_i (
        .a         (eff[0]),
        .b         (eff[1]),
        .a_zero    (zero_v[0]),
        .b_zero    (zero_v[1]),
        .gt        (gt),
        .lt        (lt),
        .eq        (eq),
        .a_below_b (a_below_b)
    );

    fpcmp_select #(.EXP_W(EXP_W), .MAN_W(MAN_W)) sel_i (
        .op        (op),
        .a         (eff[0]),
        .b         (eff[1]),
        .a_nan     (nan_v[0]),
        .b_nan     (nan_v[1]),
        .any_snan  (|snan_v),
        .a_below_b (a_below_b),
        .result    (sel_result)
    );

    always_comb begin
        rel_status = '0;
        if (|nan_v) begin
            rel_status[REL_UN] = 1'b1;
        end else begin
            rel_status[REL_GT] = gt;
            rel_status[REL_LT] = lt;
            rel_status[REL_EQ] = eq;
        end
        flag_invalid   = (op == OP_CMP_SIG) ? (|nan_v) : (|snan_v);
        flag_subnormal = !flush_sub && (|sub_v);
    end
endmodule

// File: rtl/fpcmp_unit_chk.sv
module fpcmp_unit_chk #(
    parameter int W = 32,
    parameter int MAN_W = 23
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [2:0]   op_sel,
    input logic         flush_sub,
    input logic [3:0]   rel_status,
    input logic [W-1:0] sel_result,
    input logic         flag_invalid,
    input logic         flag_subnormal
);
    localparam int EXP_W = W - MAN_W - 1;
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic a_nan, b_nan;
    assign a_nan = (&op_a[W-2:MAN_W]) && (|op_a[MAN_W-1:0]);
    assign b_nan = (&op_b[W-2:MAN_W]) && (|op_b[MAN_W-1:0]);

    always_comb begin
        if (!$isunknown({op_a, op_b, op_sel, flush_sub})) begin
            p_status_onehot_r1: assert ($countones(rel_status) == 1);
            p_unordered_nan_r2: assert (rel_status[3] == (a_nan || b_nan));
            if (op_sel == 3'd0) begin
                p_sig_invalid_r3: assert (flag_invalid == (a_nan || b_nan));
            end
            if (op_sel != 3'd0 && flag_invalid) begin
                p_quiet_invalid_r4: assert (a_nan || b_nan);
            end
            if (op_sel <= 3'd1 || op_sel >= 3'd6) begin
                p_cmp_no_data_r5: assert (sel_result == '0);
            end
            if ((op_sel == 3'd2 || op_sel == 3'd3) && !flush_sub) begin
                p_pick_operand_r6: assert (sel_result == op_a || sel_result == op_b || sel_result == QNAN);
            end
            if (flush_sub) begin
                p_flush_no_sub_r9: assert (!flag_subnormal);
            end
        end
    end
endmodule

bind fpcmp_unit fpcmp_unit_chk #(.W(W), .MAN_W(MAN_W)) chk_i (
    .op_a           (op_a),
    .op_b           (op_b),
    .op_sel         (op_sel),
    .flush_sub      (flush_sub),
    .rel_status     (rel_status),
    .sel_result     (sel_result),
    .flag_invalid   (flag_invalid),
    .flag_subnormal (flag_subnormal)
);

// File: tb/fpcmp_unit_tb_top.sv
module fpcmp_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [2:0]  op_sel = '0;
    logic        flush_sub = 1'b0;
    logic [3:0]  rel_status;
    logic [31:0] sel_result;
    logic        flag_invalid, flag_subnormal;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [31:0] QN = 32'h7FC0_0000;

    always #5 clk = ~clk;

    fpcmp_unit dut_i (
        .op_a (op_a), .op_b (op_b), .op_sel (op_sel), .flush_sub (flush_sub),
        .rel_status (rel_status), .sel_result (sel_result),
        .flag_invalid (flag_invalid), .flag_subnormal (flag_subnormal)
    );

    function automatic bit f_nan(logic [31:0] v);
        return v[30:23] == 8'hFF && v[22:0] != 0;
    endfunction
    function automatic bit f_snan(logic [31:0] v);
        return f_nan(v) && !v[22];
    endfunction
    function automatic bit f_sub(logic [31:0] v);
        return v[30:23] == 0 && v[22:0] != 0;
    endfunction
    function automatic logic [31:0] f_eff(logic [31:0] v, bit fl);
        return (fl && f_sub(v)) ? {v[31], 31'd0} : v;
    endfunction
    // numeric key: zeros collapse to 0
    function automatic longint f_key(logic [31:0] v);
        longint m = longint'(v[30:0]);
        return v[31] ? -m : m;
    endfunction
    // selection key: -0 sits one step below +0
    function automatic longint f_skey(logic [31:0] v);
        longint m = longint'(v[30:0]);
        return v[31] ? -m - 1 : m;
    endfunction

    function automatic logic [3:0] f_rel(logic [31:0] a, logic [31:0] b, bit fl);
        longint ka, kb;
        if (f_nan(a) || f_nan(b)) return 4'b1000;
        ka = f_key(f_eff(a, fl));
        kb = f_key(f_eff(b, fl));
        if (ka == kb) return 4'b0100;
        return (ka < kb) ? 4'b0010 : 4'b0001;
    endfunction

    function automatic logic [31:0] f_res(logic [31:0] a, logic [31:0] b, logic [2:0] op, bit fl);
        logic [31:0] ea = f_eff(a, fl), eb = f_eff(b, fl);
        bit pick_a_max = f_skey(ea) >= f_skey(eb);
        bit pick_a_min = f_skey(ea) <= f_skey(eb);
        case (op)
            3'd2: return (f_nan(a) || f_nan(b)) ? QN : (pick_a_max ? ea : eb);
            3'd3: return (f_nan(a) || f_nan(b)) ? QN : (pick_a_min ? ea : eb);
            3'd4, 3'd5: begin
                if (f_snan(a) || f_snan(b) || (f_nan(a) && f_nan(b))) return QN;
                if (f_nan(a)) return eb;
                if (f_nan(b)) return ea;
                return (op == 3'd4) ? (pick_a_max ? ea : eb) : (pick_a_min ? ea : eb);
            end
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] gen_val();
        logic [31:0] r = $urandom;
        case ($urandom_range(0, 7))
            0:       return {r[31], 31'd0};
            1:       return {r[31], 8'd0, r[22:0] | 23'd1};
            2:       return {r[31], 8'hFF, 23'd0};
            3:       return {r[31], 8'hFF, 1'b1, r[21:0]};
            4:       return {r[31], 8'hFF, 1'b0, r[21:0] | 22'd1};
            5:       return {r[31], 8'h7F, r[22:20], 20'd0};
            default: return {r[31], 8'd1 + 8'(r[29:23] % 8'd254), r[22:0]};
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h (a=%h b=%h op=%0d fl=%0d)",
                     req, act, exp, op_a, op_b, op_sel, flush_sub);
        end
    endtask

    task automatic apply(logic [31:0] a, logic [31:0] b, logic [2:0] op, bit fl);
        logic [31:0] ea, eb;
        @(negedge clk);
        op_a = a; op_b = b; op_sel = op; flush_sub = fl;
        #1;
        check("R1/R2 status", {28'd0, rel_status}, {28'd0, f_rel(a, b, fl)});
        if (op == 3'd0)
            check("R3 invalid", {31'd0, flag_invalid}, {31'd0, f_nan(a) || f_nan(b)});
        else
            check("R4 invalid", {31'd0, flag_invalid}, {31'd0, f_snan(a) || f_snan(b)});
        if (op <= 3'd1 || op >= 3'd6)
            check("R5 result", sel_result, 32'd0);
        else if (op <= 3'd3)
            check("R6 result", sel_result, f_res(a, b, op, fl));
        else
            check("R7 result", sel_result, f_res(a, b, op, fl));
        check(fl ? "R9 subflag" : "R8 subflag", {31'd0, flag_subnormal},
              {31'd0, !fl && (f_sub(a) || f_sub(b))});
        ea = a; eb = b;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset state: zero inputs compare equal, no flags
        @(negedge clk); #1;
        check("R1 reset status", {28'd0, rel_status}, 32'h4);
        check("R5 reset result", sel_result, 32'd0);
        // directed corners
        apply(32'h0000_0000, 32'h8000_0000, 3'd1, 1'b0);   // R2 +0 == -0
        apply(32'h0000_0000, 32'h8000_0000, 3'd2, 1'b0);   // R6 max gives +0
        check("R6 max +0", sel_result, 32'h0000_0000);
        apply(32'h8000_0000, 32'h0000_0000, 3'd3, 1'b0);   // R6 min gives -0
        check("R6 min -0", sel_result, 32'h8000_0000);
        apply(32'h7FC0_0001, 32'h3F80_0000, 3'd0, 1'b0);   // R3 qNaN signaling cmp
        apply(32'h7FC0_0001, 32'h3F80_0000, 3'd1, 1'b0);   // R4 qNaN quiet cmp
        apply(32'h7FC0_0001, 32'h3F80_0000, 3'd4, 1'b0);   // R7 maxNum picks number
        check("R7 maxNum qnan", sel_result, 32'h3F80_0000);
        apply(32'h3F80_0000, 32'h7F80_0001, 3'd5, 1'b0);   // R7 sNaN -> default
        apply(32'h7FC0_0001, 32'h4000_0000, 3'd2, 1'b0);   // R6 NaN -> default
        apply(32'h8000_0005, 32'h0000_0000, 3'd1, 1'b0);   // R8 subnormal less
        apply(32'h8000_0005, 32'h0000_0000, 3'd1, 1'b1);   // R9 flushed equal
        check("R9 flushed eq", {28'd0, rel_status}, 32'h4);
        apply(32'h8000_0005, 32'h0000_0000, 3'd3, 1'b1);   // R9 returns -0
        check("R9 flushed min", sel_result, 32'h8000_0000);
        apply(32'hFF80_0000, 32'h7F80_0000, 3'd6, 1'b0);   // R5 reserved code
        // random mix
        for (int i = 0; i < 3000; i++) begin
            apply(gen_val(), gen_val(), 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule